// File: doc/BRIEF.md
# Product Scaler with Saturation

This block sits between the two multiplier product registers and the accumulator datapath. Each of the two 32-bit products passes through its own scaling lane. A 2-bit select field on each lane picks the scale: pass, arithmetic right by 2, left by 2 or left by 1. The second lane also takes a request strobe that replaces its select with a right shift by 15. A mode bit turns that shift into a right shift by 16 followed by a left shift by 1. That variant always leaves the least significant bit at zero.

An enable bit makes both lanes clamp their scaled result to the signed 32-bit range. When a clamp actually alters the value, the lane raises its overflow flag. The two lanes compute combinationally. Their results and flags are registered once, so they line up with the next pipeline stage.

Top module: `prod_scaler`

## Requirements
- R1: Each lane uses its own 2-bit select: 2'b00 passes the product, 2'b01 shifts it arithmetic right by 2, 2'b10 shifts it left by 2, 2'b11 shifts it left by 1. The setting of one lane's select never changes the other lane's result.
- R2: Right shifts are arithmetic. Vacated upper bits are filled with copies of the input's bit 31.
- R3: While `r15_req` is 1, lane 1 ignores `p1_sel`. With `r15_alt` = 0, lane 1 yields its input shifted arithmetic right by 15.
- R4: While `r15_req` is 1 and `r15_alt` is 1, lane 1 yields (input >>> 16) << 1, so bit 0 of `p1_out` is 0.
- R5: `r15_req` and `r15_alt` have no effect on lane 0.
- R6: With `sat_en` = 0, each output is the low 32 bits of the scaled value, wrapping on overflow, and both overflow flags are 0.
- R7: With `sat_en` = 1, a scaled value above the signed 32-bit range gives 32'h7FFFFFFF and a value below it gives 32'h80000000. In either case the lane's overflow flag is 1.
- R8: With `sat_en` = 1, a scaled value inside the signed 32-bit range is output exactly, and the lane's overflow flag is 0.
- R9: Outputs and flags change one clock after their inputs. While `rst_n` is 0 they are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| p0_in | input | 32 | Product for lane 0 |
| p1_in | input | 32 | Product for lane 1 |
| p0_sel | input | 2 | Scale select for lane 0 |
| p1_sel | input | 2 | Scale select for lane 1 |
| r15_req | input | 1 | Request right-by-15 on lane 1 |
| r15_alt | input | 1 | Selects the right-16-then-left-1 variant |
| sat_en | input | 1 | Enables 32-bit clamping of both lanes |
| p0_out | output | 32 | Registered scaled product, lane 0 |
| p1_out | output | 32 | Registered scaled product, lane 1 |
| p0_ovf | output | 1 | Registered clamp flag, lane 0 |
| p1_ovf | output | 1 | Registered clamp flag, lane 1 |

## Verification
Random products are weighted toward values near the range limits and toward sign bits of either polarity. Run under all four selects with saturation on and off, they separate correct wrapping from correct clamping and arithmetic right shifts from logical ones. Directed cases pin the exact edges: 32'h3FFFFFFF and 32'h40000000 under left by 1, and the most negative value under each left shift. Lane 1 inputs with bits 15 and 16 set tell the plain right-by-15 from the variant that clears the low bit. Asserting the strobe while lane 0 scales shows that lane 0 ignores it.

// File: rtl/prod_scaler_pkg.sv
package prod_scaler_pkg;

   // Scale select encoding shared by both lanes
   typedef enum logic [1:0] {
      SH_NONE = 2'b00,
      SH_ASR2 = 2'b01,
      SH_SHL2 = 2'b10,
      SH_SHL1 = 2'b11
   } shift_sel_e;

   // Extra headroom bits carried through a lane (largest left shift)
   localparam int HEADROOM = 2;

endpackage

// File: rtl/prod_shift_unit.sv
module prod_shift_unit
   import prod_scaler_pkg::*;
#(
   parameter int DW      = 32,
   parameter bit HAS_R15 = 1'b0,
   parameter int R15_AMT = 15
) (
   input  logic [DW-1:0]          din,
   input  logic [1:0]             sel,
   input  logic                   r15_req,
   input  logic                   r15_alt,
   output logic [DW+HEADROOM-1:0] wide
);

   localparam int WW = DW + HEADROOM;

   logic signed [WW-1:0] ext;
   logic signed [WW-1:0] sel_res;

   assign ext = $signed({{HEADROOM{din[DW-1]}}, din});

   always_comb begin
      case (sel)
         SH_NONE: sel_res = ext;
         SH_ASR2: sel_res = ext >>> 2;
         SH_SHL2: sel_res = ext <<< 2;
         default: sel_res = ext <<< 1;
      endcase
   end

   generate
      if (HAS_R15) begin : g_r15
         logic signed [WW-1:0] plain_r;
         logic signed [WW-1:0] alt_r;
         assign plain_r = ext >>> R15_AMT;
         assign alt_r   = (ext >>> (R15_AMT + 1)) <<< 1;
         assign wide    = r15_req ? (r15_alt ? alt_r : plain_r) : sel_res;
      end else begin : g_plain
         logic unused_r15;
         assign unused_r15 = ^{r15_req, r15_alt};
         assign wide       = sel_res;
      end
   endgenerate

endmodule

// File: rtl/prod_sat_unit.sv
module prod_sat_unit
   import prod_scaler_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [DW+HEADROOM-1:0] wide,
   input  logic                   sat_en,
   output logic [DW-1:0]          dout,
   output logic                   ovf
);

   localparam int WW = DW + HEADROOM;
   localparam logic [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

   logic [HEADROOM:0] head;
   logic              fits;
   logic              clip;

   // Value fits when headroom bits all equal the target sign bit
   assign head = wide[WW-1:DW-1];
   assign fits = (&head) | (~|head);
   assign clip = sat_en & ~fits;

   always_comb begin
      if (clip) begin
         dout = wide[WW-1] ? NEG_LIM : POS_LIM;
      end else begin
         dout = wide[DW-1:0];
      end
   end

   assign ovf = clip;

endmodule

// File: rtl/prod_scaler.sv
module prod_scaler
   import prod_scaler_pkg::*;
#(
   parameter int DW      = 32,
   parameter int R15_AMT = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] p0_in,
   input  logic [DW-1:0] p1_in,
   input  logic [1:0]    p0_sel,
   input  logic [1:0]    p1_sel,
   input  logic          r15_req,
   input  logic          r15_alt,
   input  logic          sat_en,
   output logic [DW-1:0] p0_out,
   output logic [DW-1:0] p1_out,
   output logic          p0_ovf,
   output logic          p1_ovf
);

   localparam int NLANE = 2;
   localparam int WW    = DW + HEADROOM;

   generate
      if (DW < R15_AMT + 3) begin : g_bad_width
         $error("prod_scaler: DW must exceed R15_AMT + 2");
      end
      if (R15_AMT < 1) begin : g_bad_amt
         $error("prod_scaler: R15_AMT must be at least 1");
      end
   endgenerate

   logic [DW-1:0] lane_in  [NLANE];
   logic [1:0]    lane_sel [NLANE];
   logic [WW-1:0] lane_wide[NLANE];
   logic [DW-1:0] lane_d   [NLANE];
   logic          lane_ovf [NLANE];
   logic [DW-1:0] lane_q   [NLANE];
   logic          lane_fq  [NLANE];

   assign lane_in[0]  = p0_in;
   assign lane_in[1]  = p1_in;
   assign lane_sel[0] = p0_sel;
   assign lane_sel[1] = p1_sel;

   generate
      for (genvar i = 0; i < NLANE; i++) begin : g_lane
         prod_shift_unit #(
            .DW      (DW),
            .HAS_R15 (i == 1),
            .R15_AMT (R15_AMT)
         ) u_shift (
            .din     (lane_in[i]),
            .sel     (lane_sel[i]),
            .r15_req (r15_req),
            .r15_alt (r15_alt),
            .wide    (lane_wide[i])
         );

         prod_sat_unit #(
            .DW (DW)
         ) u_sat (
            .wide   (lane_wide[i]),
            .sat_en (sat_en),
            .dout   (lane_d[i]),
            .ovf    (lane_ovf[i])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_q[i]  <= '0;
               lane_fq[i] <= 1'b0;
            end else begin
               lane_q[i]  <= lane_d[i];
               lane_fq[i] <= lane_ovf[i];
            end
         end
      end
   endgenerate

   assign p0_out = lane_q[0];
   assign p1_out = lane_q[1];
   assign p0_ovf = lane_fq[0];
   assign p1_ovf = lane_fq[1];

endmodule

// File: rtl/prod_scaler_chk.sv
module prod_scaler_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic [DW-1:0] p0_in,
   input logic [DW-1:0] p1_in,
   input logic [1:0]    p0_sel,
   input logic [1:0]    p1_sel,
   input logic          r15_req,
   input logic          r15_alt,
   input logic          sat_en,
   input logic [DW-1:0] p0_out,
   input logic [DW-1:0] p1_out,
   input logic          p0_ovf,
   input logic          p1_ovf
);

   localparam logic [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(p0_sel) == 2'b00 |-> p0_out == $past(p0_in)); // R1

   AST_ASR2_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(p0_sel) == 2'b01 |-> p0_out[DW-1:DW-3] == {3{$past(p0_in[DW-1])}}); // R2

   AST_R15_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(r15_req) && !$past(r15_alt)
      |-> p1_out == DW'($signed($past(p1_in)) >>> 15)); // R3

   AST_R15_ALT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(r15_req) && $past(r15_alt) |-> !p1_out[0]); // R4

   AST_NO_FLAG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !$past(sat_en) |-> !p0_ovf && !p1_ovf); // R6

   AST_CLAMP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      p0_ovf |-> (p0_out == POS_LIM) || (p0_out == NEG_LIM)); // R7

   AST_CLAMP_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && p1_ovf |-> p1_out[DW-1] == $past(p1_in[DW-1])); // R7

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(p0_sel) == 2'b01 |-> !p0_ovf); // R8

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_ZERO: assert (p0_out == '0 && p1_out == '0 && !p0_ovf && !p1_ovf); // R9
      end
   end

endmodule

bind prod_scaler prod_scaler_chk #(.DW(DW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .p0_in   (p0_in),
   .p1_in   (p1_in),
   .p0_sel  (p0_sel),
   .p1_sel  (p1_sel),
   .r15_req (r15_req),
   .r15_alt (r15_alt),
   .sat_en  (sat_en),
   .p0_out  (p0_out),
   .p1_out  (p1_out),
   .p0_ovf  (p0_ovf),
   .p1_ovf  (p1_ovf)
);

// File: tb/tb_prod_scaler.sv
module tb_prod_scaler;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] p0_in = '0, p1_in = '0;
   logic [1:0]  p0_sel = '0, p1_sel = '0;
   logic        r15_req = 1'b0, r15_alt = 1'b0, sat_en = 1'b0;
   logic [31:0] p0_out, p1_out;
   logic        p0_ovf, p1_ovf;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   prod_scaler dut (
      .clk(clk), .rst_n(rst_n), .p0_in(p0_in), .p1_in(p1_in),
      .p0_sel(p0_sel), .p1_sel(p1_sel), .r15_req(r15_req),
      .r15_alt(r15_alt), .sat_en(sat_en), .p0_out(p0_out),
      .p1_out(p1_out), .p0_ovf(p0_ovf), .p1_ovf(p1_ovf)
   );

   // Reference: {ovf, value} computed from the requirements with wide integers
   function automatic logic [32:0] model(input logic [31:0] d, input logic [1:0] sel,
                                         input bit r15, input bit alt, input bit sat);
      longint v, r;
      v = longint'($signed(d));
      if (r15) r = alt ? ((v >>> 16) * 2) : (v >>> 15);
      else begin
         case (sel)
            2'b00:   r = v;
            2'b01:   r = v >>> 2;
            2'b10:   r = v * 4;
            default: r = v * 2;
         endcase
      end
      if (sat && r > 64'sd2147483647)  return {1'b1, 32'h7FFFFFFF};
      if (sat && r < -64'sd2147483648) return {1'b1, 32'h80000000};
      return {1'b0, r[31:0]};
   endfunction

   function automatic string tag0(input logic [1:0] sel, input bit sat, input bit ovf, input bit r15);
      if (r15)        return "R5";
      if (ovf)        return "R7";
      if (!sat)       return (sel[1]) ? "R6" : "R1";
      if (sel == 2'b01) return "R2";
      return "R8";
   endfunction

   task automatic check(input string req, input string what,
                        input logic [32:0] act, input logic [32:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Drive at a falling edge, check after the next rising edge
   task automatic apply(input logic [31:0] a, input logic [31:0] b,
                        input logic [1:0] s0, input logic [1:0] s1,
                        input bit rq, input bit al, input bit sat);
      logic [32:0] e0, e1;
      string t1;
      @(negedge clk);
      p0_in = a; p1_in = b; p0_sel = s0; p1_sel = s1;
      r15_req = rq; r15_alt = al; sat_en = sat;
      e0 = model(a, s0, 1'b0, 1'b0, sat);
      e1 = model(b, s1, rq, al, sat);
      if (rq) t1 = al ? "R4" : "R3";
      else    t1 = tag0(s1, sat, e1[32], 1'b0);
      @(negedge clk);
      check(tag0(s0, sat, e0[32], rq), "lane0", {p0_ovf, p0_out}, e0);
      check(t1, "lane1", {p1_ovf, p1_out}, e1);
   endtask

   function automatic logic [31:0] edgy(input int unsigned r);
      case (r % 6)
         0: return 32'h3FFFFFFF + (r % 5) - 2;
         1: return 32'hC0000000 + (r % 5) - 2;
         2: return 32'h1FFFFFFF + (r % 5) - 2;
         3: return 32'hE0000000 + (r % 5) - 2;
         default: return $urandom;
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R9 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      p0_in = 32'h12345678; p1_in = 32'h87654321;
      repeat (3) @(negedge clk);
      check("R9", "reset lane0", {p0_ovf, p0_out}, 33'h0);
      check("R9", "reset lane1", {p1_ovf, p1_out}, 33'h0);
      rst_n = 1'b1;

      // Directed corners
      apply(32'h40000000, 32'h3FFFFFFF, 2'b11, 2'b11, 0, 0, 1); // R7 / R8 edge
      apply(32'h80000000, 32'h80000000, 2'b10, 2'b11, 0, 0, 1); // R7 negative
      apply(32'h20000000, 32'h1FFFFFFF, 2'b10, 2'b10, 0, 0, 0); // R6 wrap
      apply(32'h1FFFFFFF, 32'hE0000000, 2'b10, 2'b10, 0, 0, 1); // R8 fits
      apply(32'hFFFFFFFF, 32'h80000003, 2'b01, 2'b01, 0, 0, 1); // R2
      apply(32'h7FFFFFFF, 32'h00018001, 2'b11, 2'b10, 1, 0, 1); // R3, R5
      apply(32'h7FFFFFFF, 32'h00018001, 2'b11, 2'b10, 1, 1, 1); // R4, R5
      apply(32'hCAFEF00D, 32'hFFFF7FFF, 2'b00, 2'b11, 1, 1, 0); // R4 negative
      apply(32'hCAFEF00D, 32'hFFFF7FFF, 2'b00, 2'b11, 1, 0, 0); // R3 negative

      // Constrained random
      for (int i = 0; i < 600; i++) begin
         int unsigned r;
         r = $urandom;
         apply(edgy($urandom), edgy($urandom), 2'(r), 2'(r >> 2),
               ((r >> 4) % 4) == 0, r[5], r[6]);
      end

      // Reset mid-run clears outputs
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R9", "reset again lane0", {p0_ovf, p0_out}, 33'h0);
      check("R9", "reset again lane1", {p1_ovf, p1_out}, 33'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule